// File: doc/BRIEF.md
# Phase-Accumulator Waveform Generator

The block produces one unsigned 8-bit waveform sample for each sample-request strobe. A 16-bit phase register, holding a 7-bit table index above 9 fractional bits, advances by a programmable increment on each strobe. The output frequency is therefore set by the increment word, while the sample rate stays at whatever rate the downstream converter can accept. An increment of 512 (one whole index step) walks the 128-entry sine table once per 128 samples. Larger or non-integer increments raise the frequency in proportion.

A select input chooses one of four shapes. Sine is read from a 128-entry table and can be linearly interpolated between neighbouring entries using the fractional phase bits. Square, ramp and triangle are computed directly from the upper phase bits. Each sample is registered and appears together with a one-cycle valid pulse in the cycle after its strobe. The sample is always computed from the phase before that strobe's advance.

Top module: `wavegen`

## Requirements
- R1: While reset is low, and in the first cycle after reset rises, sample_o is 0 and valid_o is 0. The first sample after reset is computed from phase 0.
- R2: valid_o is 1 in exactly the cycle after each cycle in which strobe_i is 1, and 0 otherwise.
- R3: The phase advances by inc_i modulo 2^16 on each strobe and on no other cycle. Sample n after reset uses phase (sum of the first n increments) mod 2^16, so inc_i = 0 repeats the same sample.
- R4: With sel_i = 0 (sine) and interp_i = 0, the sample is table[i] with i = phase[15:9], where table[k] = floor(127.5 + 127.5*sin(2*pi*k/128) + 0.5), giving a range of 0 to 255.
- R5: An increment of 512 passes through all 128 table entries in order, one per sample. An increment of 1024 visits every second entry and repeats after 64 samples.
- R6: With sel_i = 1 (square), the sample is 255 when phase[15] is 0 and 0 when phase[15] is 1.
- R7: With sel_i = 2 (ramp), the sample is phase[15:8].
- R8: With sel_i = 3 (triangle), the sample is phase[14:7] when phase[15] is 0 and 255 minus phase[14:7] when phase[15] is 1.
- R9: With sel_i = 0 and interp_i = 1, the sample is table[i] + floor((table[(i+1) mod 128] - table[i]) * phase[8:0] / 512), and index 127 pairs with index 0. In the other modes interp_i has no effect.
- R10: sample_o holds its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample request; advances the phase and registers one sample |
| inc_i | input | 16 | Phase increment: 7 integer index bits above 9 fractional bits |
| sel_i | input | 2 | Waveform: 0 sine, 1 square, 2 ramp, 3 triangle |
| interp_i | input | 1 | Enables linear interpolation in sine mode |
| sample_o | output | 8 | Unsigned waveform sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The assertions check four things on every cycle. The phase and the sample stay frozen between strobes, and a strobe is always followed by a valid pulse. A square sample only ever takes its two rail values. An interpolated sine value never leaves the span of its two table entries and never carries out of 8 bits. Only the bench's scenarios can show the exact values of each shape along the phase: the sine table contents, the floor rounding of the interpolation including the pairing of entry 127 with entry 0, the period for a given increment, and the return to phase 0 after a reset in the middle of a run.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_SQUARE = 2'd1,
    WAVE_RAMP   = 2'd2,
    WAVE_TRI    = 2'd3
  } wave_e;
endpackage

// File: rtl/wg_phase_acc.sv
module wg_phase_acc #(
  parameter int PH_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [PH_W-1:0] inc_i,
  output logic [PH_W-1:0] phase_o
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (step_i) phase_q <= phase_q + inc_i;  // wraps modulo 2^PH_W
  end

  assign phase_o = phase_q;

  p_phase_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q));
endmodule

// File: rtl/wg_sine_lut.sv
module wg_sine_lut #(
  parameter int IDX_W  = 7,
  parameter int FRAC_W = 9,
  parameter int SAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              interp_i,
  output logic [SAMP_W-1:0] sample_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PW    = SAMP_W + FRAC_W + 2;

  function automatic logic [SAMP_W-1:0] sine_at(int k);
    real amp;
    real ang;
    amp = (2.0 ** SAMP_W - 1.0) / 2.0;
    ang = 2.0 * 3.14159265358979 * k / DEPTH;
    return SAMP_W'($rtoi(amp + amp * $sin(ang) + 0.5));
  endfunction

  logic [SAMP_W-1:0] rom [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = sine_at(k);
  end

  logic [IDX_W-1:0]    idx_nxt;
  logic [SAMP_W-1:0]   t0, t1;
  logic signed [SAMP_W:0] diff;
  logic signed [PW-1:0] prod, shifted, sum;

  assign idx_nxt = idx_i + 1'b1;  // last entry pairs with first
  assign t0      = rom[idx_i];
  assign t1      = rom[idx_nxt];
  assign diff    = $signed({1'b0, t1}) - $signed({1'b0, t0});
  assign prod    = diff * $signed({1'b0, frac_i});
  assign shifted = prod >>> FRAC_W;  // floor
  assign sum     = $signed({{(FRAC_W+2){1'b0}}, t0}) + shifted;

  assign sample_o = interp_i ? sum[SAMP_W-1:0] : t0;

  p_interp_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interp_i |-> sum[PW-1:SAMP_W] == '0);

  p_interp_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interp_i |-> ((sample_o >= t0 && sample_o <= t1) || (sample_o <= t0 && sample_o >= t1)));
endmodule

// File: rtl/wg_shape.sv
module wg_shape #(
  parameter int SAMP_W = 8
) (
  input  wg_pkg::wave_e     sel_i,
  input  logic [SAMP_W:0]   top_i,   // upper SAMP_W+1 phase bits
  input  logic [SAMP_W-1:0] sine_i,
  output logic [SAMP_W-1:0] sample_o
);
  import wg_pkg::*;

  logic [SAMP_W-1:0] square, ramp, tri_w;

  assign square = top_i[SAMP_W] ? '0 : '1;
  assign ramp   = top_i[SAMP_W:1];
  assign tri_w  = top_i[SAMP_W] ? ~top_i[SAMP_W-1:0] : top_i[SAMP_W-1:0];

  always_comb begin
    unique case (sel_i)
      WAVE_SINE:   sample_o = sine_i;
      WAVE_SQUARE: sample_o = square;
      WAVE_RAMP:   sample_o = ramp;
      default:     sample_o = tri_w;
    endcase
  end
endmodule

// File: rtl/wavegen.sv
module wavegen #(
  parameter int IDX_W  = 7,
  parameter int FRAC_W = 9,
  parameter int SAMP_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_i,
  input  logic [IDX_W+FRAC_W-1:0] inc_i,
  input  logic [1:0]              sel_i,
  input  logic                    interp_i,
  output logic [SAMP_W-1:0]       sample_o,
  output logic                    valid_o
);
  import wg_pkg::*;

  localparam int PH_W = IDX_W + FRAC_W;

  logic [PH_W-1:0]   phase;
  logic [SAMP_W-1:0] sine, shaped, sample_q;
  logic              valid_q;
  wave_e             sel;

  assign sel = wave_e'(sel_i);

  wg_phase_acc #(.PH_W(PH_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (strobe_i),
    .inc_i  (inc_i),
    .phase_o(phase)
  );

  wg_sine_lut #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .SAMP_W(SAMP_W)) u_lut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (phase[PH_W-1:FRAC_W]),
    .frac_i  (phase[FRAC_W-1:0]),
    .interp_i(interp_i),
    .sample_o(sine)
  );

  wg_shape #(.SAMP_W(SAMP_W)) u_shape (
    .sel_i   (sel),
    .top_i   (phase[PH_W-1 -: SAMP_W+1]),
    .sine_i  (sine),
    .sample_o(shaped)
  );

  // sample taken from the phase before this strobe's advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= strobe_i;
      if (strobe_i) sample_q <= shaped;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

  p_sample_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(sample_o));

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);

  p_square_levels_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && sel_i == 2'd1) |=> (sample_o == '0 || sample_o == '1));
endmodule

// File: tb/sim_wavegen.sv
`timescale 1ns/1ps
module sim_wavegen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [15:0] inc_i = '0;
  logic [1:0]  sel_i = '0;
  logic        interp_i = 1'b0;
  logic [7:0]  sample_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int ph = 0;
  int cap [128];

  always #2.5 clk = ~clk;

  wavegen u0 (.clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe_i), .inc_i(inc_i),
              .sel_i(sel_i), .interp_i(interp_i), .sample_o(sample_o), .valid_o(valid_o));

  // [31:30] sel, [28] interp, [27:12] inc, [11:0] sample count
  localparam logic [31:0] VEC [7] = '{
    {2'd0, 1'b0, 1'b1, 16'h00C5, 12'd400},  // R9 sine interp
    {2'd0, 1'b0, 1'b1, 16'h0203, 12'd200},  // R9 wrap of index 127
    {2'd1, 1'b0, 1'b0, 16'h0300, 12'd100},  // R6
    {2'd2, 1'b0, 1'b0, 16'h0111, 12'd300},  // R7
    {2'd3, 1'b0, 1'b0, 16'h0187, 12'd300},  // R8
    {2'd1, 1'b0, 1'b1, 16'h0405, 12'd100},  // R9 interp ignored, square
    {2'd3, 1'b0, 1'b1, 16'h7FFF, 12'd50}    // R9 interp ignored, triangle
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(int sel, bit ip, int p);
    int i, f, t0, t1, d;
    i = (p >> 9) & 127;
    f = p & 511;
    case (sel)
      0: begin
        t0 = cap[i];
        if (!ip) return t0;
        t1 = cap[(i + 1) % 128];
        d = t1 - t0;
        return t0 + ((d * f) >>> 9);
      end
      1: return ((p >> 15) & 1) ? 0 : 255;
      2: return (p >> 8) & 255;
      default: return ((p >> 15) & 1) ? 255 - ((p >> 7) & 255) : (p >> 7) & 255;
    endcase
  endfunction

  task automatic pulse(int inc);
    @(negedge clk);
    inc_i = inc[15:0];
    strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
  endtask

  task automatic run_one(string req, int sel, bit ip, int inc);
    int e;
    sel_i = sel[1:0];
    interp_i = ip;
    e = model(sel, ip, ph);
    pulse(inc);
    check("R2 valid", int'(valid_o), 1);
    check(req, int'(sample_o), e);
    ph = (ph + inc) & 16'hFFFF;
  endtask

  initial begin
    int ref_v, s0;
    repeat (3) @(negedge clk);
    check("R1 reset sample", int'(sample_o), 0);
    check("R1 reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset valid", int'(valid_o), 0);

    // R4/R5: capture the table with a one-entry step
    sel_i = 2'd0; interp_i = 1'b0;
    for (int k = 0; k < 128; k++) begin
      pulse(512);
      check("R2 valid", int'(valid_o), 1);
      ref_v = $rtoi(127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * k / 128.0) + 0.5);
      n_chk++;
      if (int'(sample_o) > ref_v + 1 || int'(sample_o) + 1 < ref_v) begin
        n_bad++;
        $display("FAIL R4 entry %0d: actual %0d expected %0d", k, sample_o, ref_v);
      end
      cap[k] = int'(sample_o);
    end
    check("R4 entry 0", cap[0], 128);
    check("R4 peak", cap[32], 255);
    check("R4 trough", cap[96], 0);
    ph = 0;

    // R5: double step, period 64
    for (int k = 0; k < 64; k++) begin
      pulse(1024);
      check("R5 double step", int'(sample_o), cap[(2 * k) % 128]);
    end
    pulse(0);
    check("R5 period 64", int'(sample_o), cap[0]);

    foreach (VEC[v]) begin
      string req;
      int sel;
      sel = int'(VEC[v][31:30]);
      case (sel)
        0: req = "R9 interp";
        1: req = "R6 square";
        2: req = "R7 ramp";
        default: req = "R8 triangle";
      endcase
      if (sel != 0 && VEC[v][28]) req = "R9 interp ignored";
      for (int n = 0; n < int'(VEC[v][11:0]); n++)
        run_one(req, sel, VEC[v][28], int'(VEC[v][27:12]));
    end

    // R10: hold between strobes
    run_one("R7 ramp", 2, 0, 16'h0900);
    s0 = int'(sample_o);
    repeat (4) begin
      @(negedge clk);
      check("R10 hold", int'(sample_o), s0);
      check("R2 no strobe", int'(valid_o), 0);
    end
    run_one("R3 single advance", 2, 0, 16'h0900);

    // R3: zero increment repeats
    for (int n = 0; n < 4; n++) run_one("R3 zero inc", 3, 0, 0);

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 mid reset sample", int'(sample_o), 0);
    check("R1 mid reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    ph = 0;
    run_one("R1 phase restarts", 2, 0, 16'h1234);
    run_one("R3 after reset", 2, 0, 16'h1234);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule